// File: doc/BRIEF.md
# Serial Data Validity Monitor

This block watches a recovered serial stream, taken one bit per clock when a bit-valid strobe is high, and decides whether it looks like properly encoded 8b/10b traffic. Two faults are looked for: a run of identical bits that is too long, and a window that does not contain the leading seven bits of a positive-disparity comma character. Both faults are remembered until the window they were seen in ends.

The verdict is a single registered flag. It moves only at window boundaries. A window with any fault pulls the flag low from the start of the next window. A window with no fault lifts it high from the start of the next window. The result is hysteresis tied to the window: one bad bit keeps the flag low for at least one full window, and recovery needs one full clean window. The window length is a power of two, counted in accepted bits; the default is 2^15.

Typical use sits after a clock recovery stage. The flag gates whether a port's data is allowed onto a shared loop.

Top module: `sdv_monitor`

## Requirements
- R1: While `rst_ni` is low or `en_i` is low, `data_ok_o` is 0 from the next clock on and all tracking state is cleared. After `en_i` returns high, a full window of 2^WIN_LOG2 accepted bits has to be seen before the flag can rise.
- R2: An accepted bit that is the (RUN_MAX+1)-th identical bit in a row (the sixth by default) marks the current window as faulty. This holds for runs of ones and runs of zeros. A run of exactly RUN_MAX bits is no fault.
- R3: A comma is seen when the seven most recently accepted bits, oldest first, equal 0011111. Only bits accepted since the last clear take part in the match.
- R4: A window is exactly 2^WIN_LOG2 accepted bits, counted from the last clear. Clocks with `bit_vld_i` low advance nothing, whatever `bit_i` carries.
- R5: A window in which no comma is seen is faulty. A match that straddles a window boundary belongs to the window of its last bit. The fault memory of both kinds is emptied when a window ends.
- R6: `data_ok_o` changes only on the clock that accepts the final bit of a window, or because of R1.
- R7: On the clock that accepts a window's final bit, `data_ok_o` becomes 1 if that window had no run fault and at least one comma, and 0 otherwise. It therefore stays low until a clean window completes.
- R8: The run-length tracking and the comma history carry across window boundaries unchanged, so a run or a comma can span two windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitor enable; low clears all state |
| bit_i | input | 1 | Recovered serial bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` on this clock |
| data_ok_o | output | 1 | Stream judged valid when high |

## Verification
The bench builds the monitor with WIN_LOG2 = 6, a 64-bit window, and keeps the default run limit of five and the standard comma pattern. The short window brings dozens of boundaries within a few thousand cycles. At that scale the bench can place runs and comma matches exactly on a boundary, interleave strobe gaps carrying misleading bit values, and show a window that is clean only because of bits carried over from the previous one. A random phase with sticky bit values, injected commas and enable drops then runs against a bench model of the window rules.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
  localparam int unsigned COMMA_W = 7;
  localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111;

  typedef struct packed {
    logic run;
    logic comma;
  } sdv_hit_t;
endpackage

// File: rtl/sdv_win_ctr.sv
module sdv_win_ctr #(
  parameter int unsigned WIN_LOG2 = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                adv_i,
  output logic [WIN_LOG2-1:0] cnt_o,
  output logic                last_o
);
  logic [WIN_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q;
endmodule

// File: rtl/sdv_run_chk.sv
module sdv_run_chk #(
  parameter int unsigned RUN_MAX = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(RUN_MAX + 2);
  localparam logic [CW-1:0] SAT = CW'(RUN_MAX + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_MAX);

  logic          last_q;
  logic [CW-1:0] len_q, len_nx;

  // len_q == 0 means no bit seen since clear
  always_comb begin
    if (len_q != '0 && bit_i == last_q)
      len_nx = (len_q == SAT) ? SAT : len_q + 1'b1;
    else
      len_nx = CW'(1);
  end

  assign hit_o = adv_i && (len_nx > LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      len_q  <= '0;
    end else if (clr_i) begin
      last_q <= 1'b0;
      len_q  <= '0;
    end else if (adv_i) begin
      last_q <= bit_i;
      len_q  <= len_nx;
    end
  end
endmodule

// File: rtl/sdv_comma_det.sv
module sdv_comma_det #(
  parameter int unsigned          PAT_W = sdv_pkg::COMMA_W,
  parameter logic [PAT_W-1:0]     PAT   = sdv_pkg::COMMA_PAT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int unsigned HW = PAT_W - 1;
  localparam int unsigned FW = $clog2(PAT_W);
  localparam logic [FW-1:0] FULL = FW'(HW);

  logic [HW-1:0] hist_q;
  logic [FW-1:0] fill_q;

  // oldest bit sits in the MSB of the compare word
  assign hit_o = adv_i && (fill_q == FULL) && ({hist_q, bit_i} == PAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (adv_i) begin
      hist_q <= {hist_q[HW-2:0], bit_i};
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdv_monitor.sv
module sdv_monitor #(
  parameter int unsigned          WIN_LOG2 = 15,
  parameter int unsigned          RUN_MAX  = 5,
  parameter int unsigned          PAT_W    = sdv_pkg::COMMA_W,
  parameter logic [PAT_W-1:0]     PAT      = sdv_pkg::COMMA_PAT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  input  logic bit_vld_i,
  output logic data_ok_o
);
  import sdv_pkg::*;

  logic                adv, clr;
  logic                win_last;
  logic [WIN_LOG2-1:0] win_cnt;
  logic                run_hit, comma_hit;
  sdv_hit_t            hit;
  logic                rl_err_q, cm_seen_q, ok_q;
  logic                win_bad;

  assign adv = en_i & bit_vld_i;
  assign clr = ~en_i;

  sdv_win_ctr #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr), .adv_i(adv),
    .cnt_o (win_cnt), .last_o(win_last)
  );

  sdv_run_chk #(.RUN_MAX(RUN_MAX)) u_run (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr), .adv_i(adv),
    .bit_i (bit_i), .hit_o(run_hit)
  );

  sdv_comma_det #(.PAT_W(PAT_W), .PAT(PAT)) u_comma (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr), .adv_i(adv),
    .bit_i (bit_i), .hit_o(comma_hit)
  );

  assign hit.run   = run_hit;
  assign hit.comma = comma_hit;

  // fault state of the window including the bit accepted now
  assign win_bad = rl_err_q | hit.run | ~(cm_seen_q | hit.comma);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rl_err_q  <= 1'b0;
      cm_seen_q <= 1'b0;
      ok_q      <= 1'b0;
    end else if (clr) begin
      rl_err_q  <= 1'b0;
      cm_seen_q <= 1'b0;
      ok_q      <= 1'b0;
    end else if (adv) begin
      if (win_last) begin
        ok_q      <= ~win_bad;
        rl_err_q  <= 1'b0;
        cm_seen_q <= 1'b0;
      end else begin
        rl_err_q  <= rl_err_q  | hit.run;
        cm_seen_q <= cm_seen_q | hit.comma;
      end
    end
  end

  assign data_ok_o = ok_q;
endmodule

// File: rtl/sdv_monitor_chk.sv
module sdv_monitor_chk #(
  parameter int unsigned WCW = 15
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           bit_vld_i,
  input logic           data_ok_o,
  input logic           win_last_i,
  input logic [WCW-1:0] win_cnt_i,
  input logic           rl_err_i,
  input logic           cm_seen_i
);
  p_off_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !data_ok_o);

  p_sticky_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rl_err_i && !(bit_vld_i && win_last_i)) |=> rl_err_i);

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bit_vld_i) |=> $stable(win_cnt_i));

  p_flags_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bit_vld_i && win_last_i) |=> (!rl_err_i && !cm_seen_i));

  p_hold_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(bit_vld_i && win_last_i)) |=> $stable(data_ok_o));

  p_err_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bit_vld_i && win_last_i && rl_err_i) |=> !data_ok_o);
endmodule

bind sdv_monitor sdv_monitor_chk #(.WCW(WIN_LOG2)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .bit_vld_i (bit_vld_i),
  .data_ok_o (data_ok_o),
  .win_last_i(win_last),
  .win_cnt_i (win_cnt),
  .rl_err_i  (rl_err_q),
  .cm_seen_i (cm_seen_q)
);

// File: tb/sdv_monitor_tb.sv
module sdv_monitor_tb;
  localparam int CLK_P    = 10;
  localparam int WIN_LOG2 = 6;
  localparam int WIN      = 1 << WIN_LOG2;
  localparam int RUN_MAX  = 5;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, bi = 1'b0, vld = 1'b0;
  logic data_ok;

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  int gi = 0;

  // two commas of opposite disparity, runs never exceed five
  localparam logic [19:0] GOOD = 20'b0011111010_1100000101;

  always #(CLK_P/2) clk = ~clk;

  sdv_monitor #(.WIN_LOG2(WIN_LOG2), .RUN_MAX(RUN_MAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_i(bi), .bit_vld_i(vld),
    .data_ok_o(data_ok)
  );

  // reference model of the window rules
  logic       m_ok = 1'b0, m_last = 1'b0, m_rl = 1'b0, m_cm = 1'b0;
  logic [6:0] m_hist = '0;
  int         m_wc = 0, m_run = 0, m_fill = 0;

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_ok = 0; m_wc = 0; m_run = 0; m_last = 0; m_hist = '0;
      m_fill = 0; m_rl = 0; m_cm = 0;
    end else if (vld) begin
      if (m_run > 0 && bi == m_last) m_run++; else m_run = 1;
      m_last = bi;
      m_hist = {m_hist[5:0], bi};
      if (m_fill < 7) m_fill++;
      if (m_run > RUN_MAX) m_rl = 1;
      if (m_fill == 7 && m_hist == 7'b0011111) m_cm = 1;
      if (m_wc == WIN - 1) begin
        m_ok = !(m_rl || !m_cm); m_rl = 0; m_cm = 0; m_wc = 0;
      end else m_wc++;
    end
  end

  function automatic logic good_bit(int i);
    return GOOD[19 - (i % 20)];
  endfunction

  task automatic cmp_model();
    n_cmp++;
    if (data_ok !== m_ok) begin
      n_bad++;
      $display("FAIL %s model: actual=%b expected=%b t=%0t", cur_tag, data_ok, m_ok, $time);
    end
  endtask

  task automatic check_val(string tag, logic exp);
    n_cmp++;
    if (data_ok !== exp) begin
      n_bad++;
      $display("FAIL %s directed: actual=%b expected=%b t=%0t", tag, data_ok, exp, $time);
    end
  endtask

  task automatic step(logic b, logic v, logic e);
    bi = b; vld = v; en = e;
    @(posedge clk); #(CLK_P/4);
    cmp_model();
    @(negedge clk);
  endtask

  task automatic send_good();
    step(good_bit(gi), 1'b1, 1'b1);
    gi++;
  endtask

  task automatic good_to_boundary();
    do send_good(); while (m_wc != 0);
  endtask

  task automatic alt_bits(int n, logic first);
    for (int k = 0; k < n; k++) step(first ^ logic'(k[0]), 1'b1, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 check_val("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: first clean window lifts the flag exactly at its end
    cur_tag = "R7"; gi = 0;
    for (int k = 0; k < WIN - 1; k++) send_good();
    check_val("R7", 1'b0);
    send_good();
    check_val("R7", 1'b1);

    // R2: six ones
    cur_tag = "R2";
    while (gi % 20 != 7) send_good();
    step(1'b1, 1'b1, 1'b1);
    good_to_boundary();
    check_val("R2", 1'b0);
    good_to_boundary();
    check_val("R7", 1'b1);

    // R2: six zeros
    while (gi % 20 != 17) send_good();
    step(1'b0, 1'b1, 1'b1);
    good_to_boundary();
    check_val("R2", 1'b0);
    good_to_boundary();
    check_val("R2", 1'b1);

    // R5: no comma, twice; stays low
    cur_tag = "R5";
    alt_bits(WIN, 1'b1);
    check_val("R5", 1'b0);
    alt_bits(WIN, 1'b1);
    check_val("R5", 1'b0);

    // R4: strobe gaps carrying ones do not count or form runs
    cur_tag = "R4"; gi = 0;
    for (int k = 0; k < WIN - 1; k++) begin
      send_good();
      step(1'b1, 1'b0, 1'b1);
      step(1'b1, 1'b0, 1'b1);
    end
    check_val("R4", 1'b0);
    send_good();
    check_val("R4", 1'b1);

    // R8: comma straddling a boundary
    cur_tag = "R8";
    alt_bits(WIN - 3, 1'b1);
    step(1'b0, 1'b1, 1'b1); step(1'b0, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1);
    check_val("R3", 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b1);
    alt_bits(WIN - 4, 1'b0);
    check_val("R8", 1'b1);

    // R8: run straddling a boundary
    alt_bits(WIN - 3, 1'b0);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1);
    check_val("R8", 1'b0);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1);
    gi = 0;
    for (int k = 0; k < WIN - 3; k++) send_good();
    check_val("R8", 1'b0);
    good_to_boundary();
    check_val("R8", 1'b1);

    // R1: enable drop clears and restarts the window
    cur_tag = "R1";
    for (int k = 0; k < 10; k++) send_good();
    step(1'b0, 1'b1, 1'b0);
    check_val("R1", 1'b0);
    step(1'b1, 1'b1, 1'b0);
    gi = 0;
    for (int k = 0; k < WIN - 1; k++) send_good();
    check_val("R1", 1'b0);
    send_good();
    check_val("R1", 1'b1);

    // R6: random traffic against the model
    cur_tag = "R6";
    begin
      logic b = 1'b0;
      for (int k = 0; k < 6000; k++) begin
        int r = int'($urandom_range(0, 999));
        if (r < 40) begin
          for (int j = 0; j < 7; j++) step(logic'((7'b0011111 >> (6 - j)) & 1), 1'b1, 1'b1);
        end else if (r < 45) begin
          step(b, 1'b1, 1'b0);
        end else begin
          if ($urandom_range(0, 9) < 6) b = ~b;
          step(b, logic'($urandom_range(0, 9) < 8), 1'b1);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule